// File: doc/BRIEF.md
# Asynchronous SRAM Phase Sequencer

This block sits on the synchronous side of a chip and runs an external asynchronous static RAM. The RAM has a 16-bit address, a 16-bit data bus and one active-low strobe per byte lane. A client issues one read or write at a time over a valid/ready handshake. Each request carries an address, write data and a lane mask. The sequencer turns each request into a series of strobe phases. Each phase lasts a whole number of clock cycles, derived at elaboration from the clock period and the memory's nanosecond limits and always rounded upwards. This way access time, write pulse width, data set-up and bus release are all respected.

All memory-side outputs come straight from flops, so they are free of glitches. For a write, the sequencer drives the shared data bus through a separate drive-enable. It raises that enable only in the closing cycles of the write pulse and in one recovery cycle after it. Every read ends with a turn-around gap in which nothing drives the bus, so a write that follows never fights the memory's output buffers. Read data is registered on the clock edge that closes the access window. It is returned for one cycle together with the mask of the request.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, all memory strobes (select, output enable, write enable, lane strobes) are high, the data drive-enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read accepted on a clock edge holds select and output enable low and write enable high for exactly ACC cycles after that edge, ACC = max(ceil(access/period), ceil(cycle/period)), which is 4 at defaults. During this window lane strobe i is low exactly when mask bit i is 1 (bit 0 = data bits 7:0, bit 1 = bits 15:8).
- R3: Read data is sampled on the edge that ends the read window. `rsp_valid` is then high for exactly one cycle. `rsp_data` carries the sampled bytes for lanes whose mask bit is 1 and zero for the other lanes, and `rsp_mask` echoes the request mask.
- R4: After every read window, all strobes stay high and the drive-enable stays low for TURN = ceil(output-release/period) cycles (2 at defaults) before the next request can be accepted.
- R5: A write holds select and write enable low and output enable high for PULSE = max(ceil(pulse/period), ceil(select-to-end/period), SETUP + ceil(we-to-high-Z/period)) cycles (3 at defaults). Lane strobes follow the mask as in R2.
- R6: During a write, the drive-enable is high only in the last SETUP = ceil(set-up/period) cycles of the pulse (2 at defaults) and in the single recovery cycle after it. While it is high, `mem_dq_o` equals the request's write data.
- R7: A write changes only the memory lanes whose mask bit is 1. A mask of 0 leaves the word unchanged.
- R8: `mem_addr` equals the accepted address and does not change while select is low.
- R9: `req_ready` is low from the accepting edge until the turn-around (reads) or recovery cycle (writes) is over. A request held valid during that time is not taken and does not disturb the access in progress.
- R10: The drive-enable is never high while select and output enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read response |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| rsp_mask | output | 2 | Mask of the answered read |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lane_n | output | 2 | Byte-lane strobes, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_i | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive-enable for the data bus |

## Verification
The hardest case to reach is a request that is already waiting while the sequencer is still in a read turn-around or a write recovery. The memory must not be written twice, the bus must not be driven early, and the address must not move. The bench holds `req_valid` high with poisoned address and data for the whole busy period and drops it only in the last busy cycle, then checks every strobe cycle by cycle against its own phase timeline. Partial-lane writes and reads on the same word are interleaved, so that lane masking on both paths shows up in later read data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_RD_ACC   = 3'd1,
    PH_RD_TURN  = 3'd2,
    PH_WR_PULSE = 3'd3,
    PH_WR_REC   = 3'd4
  } phase_e;

  // Whole cycles covering a nanosecond limit, at least one.
  function automatic int cyc_ceil(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load) begin
      cnt_nxt = load_val;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_seq_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int ACC_CYC   = 4,
  parameter int TURN_CYC  = 2,
  parameter int PULSE_CYC = 3,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             cnt_zero,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             sel_nxt,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drv_en
);

  phase_e ph_q, ph_d;
  logic   cs_n_d, oe_n_d, we_n_d, drv_d;

  always_comb begin
    ph_d     = ph_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          load = 1'b1;
          if (req_we) begin
            ph_d     = PH_WR_PULSE;
            load_val = CNT_W'(PULSE_CYC - 1);
          end else begin
            ph_d     = PH_RD_ACC;
            load_val = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      PH_RD_ACC: begin
        if (cnt_zero) begin
          capture  = 1'b1;
          ph_d     = PH_RD_TURN;
          load     = 1'b1;
          load_val = CNT_W'(TURN_CYC - 1);
        end
      end
      PH_RD_TURN: begin
        if (cnt_zero) begin
          ph_d = PH_IDLE;
        end
      end
      PH_WR_PULSE: begin
        if (cnt_zero) begin
          ph_d     = PH_WR_REC;
          load     = 1'b1;
          load_val = '0;
        end
      end
      PH_WR_REC: begin
        ph_d = PH_IDLE;
      end
      default: begin
        ph_d = PH_IDLE;
      end
    endcase
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign sel_nxt   = (ph_d == PH_RD_ACC) || (ph_d == PH_WR_PULSE);

  always_comb begin
    cs_n_d = !sel_nxt;
    oe_n_d = (ph_d != PH_RD_ACC);
    we_n_d = (ph_d != PH_WR_PULSE);
    drv_d  = ((ph_d == PH_WR_PULSE) && (int'(cnt_nxt) < SETUP_CYC)) ||
             (ph_d == PH_WR_REC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cs_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      drv_en <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cs_n   <= cs_n_d;
      oe_n   <= oe_n_d;
      we_n   <= we_n_d;
      drv_en <= drv_d;
    end
  end

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              sel_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [LANES-1:0]  mem_lane_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [LANES-1:0]  rsp_mask
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  mask_src;
  logic [LANES-1:0]  lane_n_d;
  logic [DATA_W-1:0] cap_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign mask_src = accept ? req_mask : mask_q;
  assign lane_n_d = sel_nxt ? ~mask_src : {LANES{1'b1}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cap_d[i*LANE_W +: LANE_W] =
      mask_q[i] ? mem_dq_i[i*LANE_W +: LANE_W] : {LANE_W{1'b0}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_lane_n <= {LANES{1'b1}};
      rvalid_q   <= 1'b0;
    end else begin
      mem_lane_n <= lane_n_d;
      rvalid_q   <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rsp_mask <= '0;
    end else if (capture) begin
      rdata_q  <= cap_d;
      rsp_mask <= mask_q;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = rvalid_q;
  assign rsp_data  = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int LANES         = DATA_W / 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int RD_CYCLE_NS   = 70,
  parameter int RD_ACCESS_NS  = 70,
  parameter int OE_TO_HIZ_NS  = 25,
  parameter int WR_PULSE_NS   = 50,
  parameter int SEL_TO_END_NS = 60,
  parameter int DATA_SETUP_NS = 30,
  parameter int WE_TO_HIZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [LANES-1:0]  rsp_mask,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  localparam int ACC_CYC   = imax(cyc_ceil(RD_ACCESS_NS, CLK_PERIOD_NS),
                                  cyc_ceil(RD_CYCLE_NS, CLK_PERIOD_NS));
  localparam int TURN_CYC  = cyc_ceil(OE_TO_HIZ_NS, CLK_PERIOD_NS);
  localparam int SETUP_CYC = cyc_ceil(DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = imax(imax(cyc_ceil(WR_PULSE_NS, CLK_PERIOD_NS),
                                       cyc_ceil(SEL_TO_END_NS, CLK_PERIOD_NS)),
                                  SETUP_CYC + cyc_ceil(WE_TO_HIZ_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC   = imax(imax(ACC_CYC, TURN_CYC), PULSE_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic             rst_m_n, rst_q_n;
  logic             accept, capture, load, sel_nxt, cnt_zero;
  logic [CNT_W-1:0] load_val, cnt_nxt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .load_val (load_val),
    .cnt_nxt  (cnt_nxt),
    .cnt_zero (cnt_zero)
  );

  sram_phase_fsm #(
    .CNT_W     (CNT_W),
    .ACC_CYC   (ACC_CYC),
    .TURN_CYC  (TURN_CYC),
    .PULSE_CYC (PULSE_CYC),
    .SETUP_CYC (SETUP_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .cnt_zero  (cnt_zero),
    .cnt_nxt   (cnt_nxt),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .load      (load),
    .load_val  (load_val),
    .sel_nxt   (sel_nxt),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .drv_en    (mem_dq_oe)
  );

  sram_lane_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .accept     (accept),
    .capture    (capture),
    .sel_nxt    (sel_nxt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .mem_dq_i   (mem_dq_i),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .mem_lane_n (mem_lane_n),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_mask   (rsp_mask)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              req_ready,
  input logic              rsp_valid
);

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_cs_n && !mem_oe_n));

  // R5
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_dq_oe && !req_ready));

endmodule

bind sram_seq_ctrl sram_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;

  function automatic int ceil_cyc(input int ns);
    return (ns + 19) / 20;
  endfunction

  localparam int E_ACC   = (ceil_cyc(70) > ceil_cyc(70)) ? ceil_cyc(70) : ceil_cyc(70);
  localparam int E_TURN  = ceil_cyc(25);
  localparam int E_SETUP = ceil_cyc(30);
  localparam int E_PULSE = 3; // max(ceil 50, ceil 60, SETUP + ceil 20) at 20 ns

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_mask;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_mask;
  logic [15:0] mem_addr, mem_dq_o;
  logic [15:0] mem_dq_i;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sram_seq_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_mask (req_mask),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_mask (rsp_mask),
    .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n), .mem_lane_n (mem_lane_n), .mem_dq_o (mem_dq_o),
    .mem_dq_i (mem_dq_i), .mem_dq_oe (mem_dq_oe)
  );

  // Behavioural memory device
  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 16'h0000;
      if (!mem_lane_n[0]) w[7:0]  = mem_dq_o[7:0];
      if (!mem_lane_n[1]) w[15:8] = mem_dq_o[15:8];
      dev_mem[int'(mem_addr)] = w;
    end
  end

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_dq_i <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 16'h0000;
    else
      mem_dq_i <= 16'h5A5A;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  // One request, compared cycle by cycle with the expected phase timeline.
  task automatic run_op(input bit we, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit hold);
    int total;
    logic [15:0] exp_rd;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    exp_rd = ref_rd(a);
    exp_rd = {m[1] ? exp_rd[15:8] : 8'h00, m[0] ? exp_rd[7:0] : 8'h00};
    total = we ? (E_PULSE + 1) : (E_ACC + E_TURN);
    @(negedge clk);
    if (hold) begin
      req_addr = ~a; req_wdata = ~d; req_we = ~we;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < total; k++) begin
      bit in_win, drv_e, rv_e;
      if (k > 0) @(negedge clk);
      in_win = we ? (k < E_PULSE) : (k < E_ACC);
      drv_e  = we && ((in_win && k >= E_PULSE - E_SETUP) || k == E_PULSE);
      rv_e   = !we && (k == E_ACC);
      chk(mem_cs_n == !in_win, we ? "R5 select" : "R2 select", 32'(mem_cs_n), 32'(!in_win));
      chk(mem_oe_n == !(in_win && !we), we ? "R5 oe" : "R2 oe", 32'(mem_oe_n), 32'(!(in_win && !we)));
      chk(mem_we_n == !(in_win && we), we ? "R5 we" : "R2 we", 32'(mem_we_n), 32'(!(in_win && we)));
      chk(mem_lane_n == (in_win ? ~m : 2'b11), "R2 lane strobes", 32'(mem_lane_n),
          32'(in_win ? ~m : 2'b11));
      chk(mem_dq_oe == drv_e, we ? "R6 drive window" : "R4 no drive after read",
          32'(mem_dq_oe), 32'(drv_e));
      chk(!(mem_dq_oe && !mem_cs_n && !mem_oe_n), "R10 contention", 32'(mem_dq_oe), 32'd0);
      chk(req_ready == 1'b0, "R9 ready while busy", 32'(req_ready), 32'd0);
      chk(rsp_valid == rv_e, "R3 rsp_valid", 32'(rsp_valid), 32'(rv_e));
      if (in_win)
        chk(mem_addr == a, "R8 address held", 32'(mem_addr), 32'(a));
      if (drv_e)
        chk(mem_dq_o == d, "R6 write data", 32'(mem_dq_o), 32'(d));
      if (rv_e) begin
        chk(rsp_data == exp_rd, "R3 rsp_data", 32'(rsp_data), 32'(exp_rd));
        chk(rsp_mask == m, "R3 rsp_mask", 32'(rsp_mask), 32'(m));
      end
      if (hold && k == total - 1) req_valid = 1'b0;
    end
    if (we) begin
      logic [15:0] w;
      w = ref_rd(a);
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      ref_mem[int'(a)] = w;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n} == 5'b11111, "R1 strobes",
        32'({mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n}), 32'h1f);
    chk(mem_dq_oe == 1'b0, "R1 drive", 32'(mem_dq_oe), 32'd0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);

    run_op(1'b1, 16'h0010, 16'h1234, 2'b11, 1'b0);
    run_op(1'b0, 16'h0010, 16'h0000, 2'b11, 1'b0);
    // R7 lane-only writes read back
    run_op(1'b1, 16'h0010, 16'hABCD, 2'b01, 1'b0);
    run_op(1'b0, 16'h0010, 16'h0000, 2'b11, 1'b0);
    run_op(1'b1, 16'h0010, 16'h9988, 2'b10, 1'b0);
    run_op(1'b0, 16'h0010, 16'h0000, 2'b01, 1'b0);
    run_op(1'b0, 16'h0010, 16'h0000, 2'b10, 1'b0);
    run_op(1'b1, 16'h0010, 16'h0000, 2'b00, 1'b0);
    run_op(1'b0, 16'h0010, 16'h0000, 2'b11, 1'b0);
    // R9 requests held during busy phases, address extremes
    run_op(1'b1, 16'hFFFF, 16'hC3A5, 2'b11, 1'b1);
    run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, 1'b1);
    run_op(1'b1, 16'h0000, 16'h7E81, 2'b11, 1'b1);
    run_op(1'b0, 16'h0000, 16'h0000, 2'b11, 1'b0);
    run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, 1'b0);

    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {14'h0, lfsr[3:2]} + 16'h0010;
      run_op(lfsr[0], a, lfsr ^ 16'h5C3E, lfsr[5:4], lfsr[7]);
    end

    for (int i = 0; i < 4; i++) begin
      run_op(1'b0, 16'h0010 + 16'(i), 16'h0000, 2'b11, 1'b0);
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready at end", 32'(req_ready), 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule